// File: doc/BRIEF.md
# Recursive Split-Operand Multiplier

This block multiplies two unsigned operands and returns the complete double-width product with no truncation. It has no clock and no handshake, so the product is a pure combinational function of the two operands.

Each operand is cut into an upper half and a lower half. Four half-width products are formed from those halves. The same construction is used to build each of those four products, and this repeats down to a small base cell. With a one-bit base, the base cell is a single AND gate.

Two parameters set the size. `BASE_W` is the width of the base cell and `DEPTH` is the number of times the construction is applied. The operand width is `BASE_W * 2^DEPTH`. At each level, the upper-by-upper and lower-by-lower products occupy bit ranges that do not overlap. They are therefore joined into one word by concatenation, with no adder. The two cross products are then added into that word at an offset of half the operand width, so each level needs two additions rather than three.

Top module: `recMulTop`

## Requirements
- R1: The product `prodOut` is 2·W bits wide for W-bit operands, and it holds the full result with no overflow. For example, with W = 8, 255·255 gives 65025 (16'hFE01).
- R2: If either operand is zero, `prodOut` is zero.
- R3: If one operand is 1, `prodOut` equals the other operand, zero-extended to 2·W bits.
- R4: When DEPTH = 0 and BASE_W = 1, the block is a 1×1 multiply, and `prodOut` is the AND of the two operand bits.
- R5: If the upper halves of both operands are zero, `prodOut` equals the product of the lower halves, and the upper W bits of `prodOut` are zero.
- R6: If the lower halves of both operands are zero, `prodOut` equals the product of the upper halves shifted left by W bits, and the lower W bits of `prodOut` are zero.
- R7: If operand a has a zero upper half and operand b has a zero lower half, `prodOut` equals the lower half of a times the upper half of b, shifted left by W/2 bits. The same holds with the roles of a and b exchanged.
- R8: For every pair of W-bit operands, `prodOut` equals the arithmetic product of a and b.
- R9: If an operand is a power of two, 2^k, `prodOut` equals the other operand shifted left by k bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | BASE_W·2^DEPTH | Unsigned multiplicand |
| opB | input | BASE_W·2^DEPTH | Unsigned multiplier |
| prodOut | output | 2·BASE_W·2^DEPTH | Full-width unsigned product |

## Verification
Immediate assertions inside each recursion node are evaluated whenever that node's operands change. They cover these properties:
- A zero operand gives a zero product.
- A unit operand returns the other operand.
- When both lower halves are zero, the lower half of the product is zero.
- The two cross-term additions never make the sum smaller than the concatenated base word.

These checks apply at every level of the tree, not only at the top. Three things can only be shown by the bench's scenarios:
- the exact numeric value of each product;
- the alignment of the cross terms;
- the power-of-two shifts.

For the default 8-bit width, the bench shows these by a table of hand-computed vectors, directed cases, an exhaustive sweep of all operand pairs, and a separate one-bit instance.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Operand width for a given base width and recursion depth.
  function automatic int opWidth(input int baseW, input int depth);
    return baseW << depth;
  endfunction
endpackage

// File: rtl/baseMulCell.sv
module baseMulCell #(
  parameter int BASE_W = 1
) (
  input  logic [BASE_W-1:0]   cellA,
  input  logic [BASE_W-1:0]   cellB,
  output logic [2*BASE_W-1:0] cellProd
);
  localparam int PW = 2 * BASE_W;

  generate
    if (BASE_W == 1) begin : g_andCell
      // A one-bit by one-bit product is a single AND gate.
      assign cellProd = {1'b0, cellA[0] & cellB[0]};
    end else begin : g_rowCell
      // Shift-and-add over the partial-product rows.
      logic [PW-1:0] rowAcc;
      always_comb begin
        rowAcc = '0;
        for (int i = 0; i < BASE_W; i++) begin
          if (cellB[i]) rowAcc = rowAcc + ({{BASE_W{1'b0}}, cellA} << i);
        end
      end
      assign cellProd = rowAcc;
    end
  endgenerate

  // R2: a zero operand must give a zero product.
  always_comb begin
    if (cellA == '0 || cellB == '0)
      a_r2_cell_zero: assert (cellProd == '0);
  end
endmodule

// File: rtl/crossSumUnit.sv
module crossSumUnit #(
  parameter int HALF = 1
) (
  input  logic [2*HALF-1:0] lowLow,
  input  logic [2*HALF-1:0] lowHigh,
  input  logic [2*HALF-1:0] highLow,
  input  logic [2*HALF-1:0] highHigh,
  output logic [4*HALF-1:0] sumOut
);
  localparam int FW = 4 * HALF;

  logic [FW-1:0] joined;
  logic [FW-1:0] crossOne;
  logic [FW-1:0] crossTwo;
  logic [FW-1:0] partSum;

  // The outer products do not overlap, so they are joined without an adder.
  assign joined   = {highHigh, lowLow};
  assign crossOne = {{HALF{1'b0}}, lowHigh, {HALF{1'b0}}};
  assign crossTwo = {{HALF{1'b0}}, highLow, {HALF{1'b0}}};
  assign partSum  = joined + crossOne;
  assign sumOut   = partSum + crossTwo;

  // R1: adding the cross terms never wraps past the full product width.
  always_comb begin
    a_r1_no_overflow: assert (sumOut >= joined && partSum >= joined);
  end
endmodule

// File: rtl/splitMulNode.sv
module splitMulNode #(
  parameter int BASE_W = 1,
  parameter int DEPTH  = 0
) (
  input  logic [smul_pkg::opWidth(BASE_W, DEPTH)-1:0]   nodeA,
  input  logic [smul_pkg::opWidth(BASE_W, DEPTH)-1:0]   nodeB,
  output logic [2*smul_pkg::opWidth(BASE_W, DEPTH)-1:0] nodeProd
);
  localparam int OW = smul_pkg::opWidth(BASE_W, DEPTH);
  localparam int HW = OW / 2;

  generate
    if (DEPTH == 0) begin : g_leaf
      baseMulCell #(.BASE_W(BASE_W)) cell_i (
        .cellA(nodeA), .cellB(nodeB), .cellProd(nodeProd)
      );
    end else begin : g_split
      logic [HW-1:0]   aHi, aLo, bHi, bLo;
      logic [2*HW-1:0] pLL, pLH, pHL, pHH;

      assign aHi = nodeA[OW-1:HW];
      assign aLo = nodeA[HW-1:0];
      assign bHi = nodeB[OW-1:HW];
      assign bLo = nodeB[HW-1:0];

      splitMulNode #(.BASE_W(BASE_W), .DEPTH(DEPTH-1)) subLL_i (
        .nodeA(aLo), .nodeB(bLo), .nodeProd(pLL));
      splitMulNode #(.BASE_W(BASE_W), .DEPTH(DEPTH-1)) subLH_i (
        .nodeA(aLo), .nodeB(bHi), .nodeProd(pLH));
      splitMulNode #(.BASE_W(BASE_W), .DEPTH(DEPTH-1)) subHL_i (
        .nodeA(aHi), .nodeB(bLo), .nodeProd(pHL));
      splitMulNode #(.BASE_W(BASE_W), .DEPTH(DEPTH-1)) subHH_i (
        .nodeA(aHi), .nodeB(bHi), .nodeProd(pHH));

      crossSumUnit #(.HALF(HW)) sum_i (
        .lowLow(pLL), .lowHigh(pLH), .highLow(pHL), .highHigh(pHH),
        .sumOut(nodeProd)
      );

      // R6: zero lower halves leave the lower half of the product clear.
      always_comb begin
        if (aLo == '0 && bLo == '0)
          a_r6_low_clear: assert (nodeProd[OW-1:0] == '0);
      end
    end
  endgenerate

  // R2 and R3 are checked at every level of the tree.
  always_comb begin
    if (nodeA == '0 || nodeB == '0)
      a_r2_node_zero: assert (nodeProd == '0);
    if (nodeB == OW'(1))
      a_r3_unit_b: assert (nodeProd == {{OW{1'b0}}, nodeA});
    if (nodeA == OW'(1))
      a_r3_unit_a: assert (nodeProd == {{OW{1'b0}}, nodeB});
  end
endmodule

// File: rtl/recMulTop.sv
module recMulTop #(
  parameter int BASE_W = 1,
  parameter int DEPTH  = 3
) (
  input  logic [smul_pkg::opWidth(BASE_W, DEPTH)-1:0]   opA,
  input  logic [smul_pkg::opWidth(BASE_W, DEPTH)-1:0]   opB,
  output logic [2*smul_pkg::opWidth(BASE_W, DEPTH)-1:0] prodOut
);
  splitMulNode #(.BASE_W(BASE_W), .DEPTH(DEPTH)) root_i (
    .nodeA(opA), .nodeB(opB), .nodeProd(prodOut)
  );
endmodule

// File: tb/recMulTop_tb_top.sv
module recMulTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int NVEC = 12;
  // Each entry is {a, b, expected product}.
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd0,   8'd0,   16'h0000},
    {8'd255, 8'd255, 16'hFE01},
    {8'd1,   8'd255, 16'h00FF},
    {8'd128, 8'd128, 16'h4000},
    {8'd15,  8'd15,  16'h00E1},
    {8'd240, 8'd240, 16'hE100},
    {8'd15,  8'd240, 16'h0E10},
    {8'd240, 8'd15,  16'h0E10},
    {8'd3,   8'd5,   16'h000F},
    {8'd170, 8'd85,  16'h3872},
    {8'd200, 8'd100, 16'h4E20},
    {8'd255, 8'd0,   16'h0000}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;
  logic a1, b1;
  logic [1:0] p1;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  recMulTop #(.BASE_W(1), .DEPTH(3)) dut_i (.opA(a), .opB(b), .prodOut(p));
  recMulTop #(.BASE_W(1), .DEPTH(0)) dut1_i (.opA(a1), .opB(b1), .prodOut(p1));

  task automatic check(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [PW-1:0] exp);
    a = x; b = y;
    @(negedge clk);
    checks++;
    if (p !== exp) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", req, x, y, p, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; a1 = 1'b0; b1 = 1'b0;
    @(negedge clk);
    // Table walk (R8 with R1 edge at 255*255).
    for (int i = 0; i < NVEC; i++)
      check("R8", VECS[i][31:24], VECS[i][23:16], VECS[i][15:0]);
    check("R1", 8'd255, 8'd255, 16'd65025);
    check("R2", 8'd0, 8'd201, 16'd0);
    check("R2", 8'd77, 8'd0, 16'd0);
    check("R3", 8'd1, 8'd173, 16'd173);
    check("R3", 8'd99, 8'd1, 16'd99);
    check("R5", 8'd13, 8'd11, 16'd143);
    check("R6", 8'd16 * 8'd9, 8'd16 * 8'd14, 16'd126 << 8);
    check("R7", 8'd12, 8'd16 * 8'd7, 16'd84 << 4);
    check("R7", 8'd16 * 8'd5, 8'd9, 16'd45 << 4);
    for (int k = 0; k < W; k++)
      check("R9", 8'd181, 8'(1 << k), 16'(16'd181 << k));
    // R4: 1x1 instance behaves as AND.
    for (int v = 0; v < 4; v++) begin
      a1 = v[0]; b1 = v[1];
      @(negedge clk);
      checks++;
      if (p1 !== {1'b0, v[0] & v[1]}) begin
        errors++;
        $display("FAIL R4: a=%0d b=%0d actual=%0d expected=%0d", v[0], v[1], p1, v[0] & v[1]);
      end
    end
    // R8: exhaustive sweep.
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        check("R8", 8'(x), 8'(y), 16'(x * y));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule